// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block caches recent virtual-to-physical page mappings in front of a page table walker. Each request carries a virtual page number, a page offset and a read/write flag. The page number is compared with every stored tag at once. When an entry matches, the physical address (cached frame joined with the unchanged offset) returns in the same cycle, together with a protection result. When nothing usable matches, the block issues a walk request, waits for the walker's answer, writes the mapping into a slot, and answers the requester in the cycle the walker responds.

Slots are replaced by least-recent use. Empty slots are used before any live mapping is displaced. Each slot keeps an age value, and the ages of all slots always form a permutation. A single-cycle flush input drops every cached mapping. It is meant for an address-space switch. A walker fault goes back to the requester and leaves the cache unchanged. A write to a cached page whose modified flag is clear goes to the walker, so the walker can mark the page modified.

The requester keeps `req_valid` and its fields steady until the cycle `resp_valid` is high.

Top module: `fa_tlb`

## Requirements
- R1: After reset no mapping is cached, `walk_req_valid` and `resp_valid` are low, and the first request to any page goes to the walker.
- R2: A read, or a write to an entry whose modified flag is set, that matches a cached entry is answered in the same cycle. `resp_paddr` is {cached frame, req_off} and no walk is issued.
- R3: A request with no usable match gives no response in its first cycle. From the next cycle, `walk_req_valid` is high with `walk_req_vpn` equal to `req_vpn`, held until `walk_resp_valid`.
- R4: In the cycle `walk_resp_valid` is high, `resp_valid` is high with `resp_paddr` = {walk_resp_pfn, req_off}. The mapping is installed, so later requests to that page hit.
- R5: A walker response with `walk_resp_fault` high sets `resp_walk_fault`, forces `resp_paddr` to zero and installs nothing. A repeat request walks again.
- R6: A write whose mapping has its read-only flag set sets `resp_prot_fault`, whether it hits or comes from the walker. The read-only check takes precedence over the modified check. Reads never raise it.
- R7: A write that matches an entry whose modified flag is clear is treated as a miss. The walker's answer replaces that same slot, and all other cached mappings stay.
- R8: While any slot is empty, a fill uses an empty slot, so the first eight distinct pages after a flush all stay cached.
- R9: With all slots full, a fill replaces the least recently used mapping. Both hits (including protection-fault hits) and fills count as use.
- R10: A one-cycle `flush` pulse empties the cache, and every following request misses.
- R11: If `flush` coincides with a walker response, the response is still delivered, but the mapping is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | One-cycle pulse that invalidates every entry |
| req_valid | input | 1 | Translation request present, held until answered |
| req_write | input | 1 | Request is a write |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Page offset |
| resp_valid | output | 1 | Answer present this cycle |
| resp_paddr | output | PFN_W+OFF_W | Physical address |
| resp_prot_fault | output | 1 | Write to a read-only page |
| resp_walk_fault | output | 1 | Walker reported no valid mapping |
| walk_req_valid | output | 1 | Walk requested |
| walk_req_vpn | output | VPN_W | Page number to walk |
| walk_resp_valid | input | 1 | Walker answer present |
| walk_resp_pfn | input | PFN_W | Frame from the walker |
| walk_resp_ro | input | 1 | Read-only flag of the mapping |
| walk_resp_dirty | input | 1 | Modified flag of the mapping |
| walk_resp_fault | input | 1 | Walker found no valid mapping |

## Verification
The checks assume that the requester holds `req_valid`, `req_write`, `req_vpn` and `req_off` steady from the cycle a request appears until its answer. They also assume that the walker raises `walk_resp_valid` only while `walk_req_valid` is high, and that `flush` is a single-cycle pulse. The stimulus tasks drive a request at one falling edge and keep every request field unchanged through the walk. They raise the walker answer only in cycles where the walk is outstanding, after zero to two wait cycles. They drop `flush` at the next falling edge. Because `ENTRIES` is a power of two, the slot ages cover exactly 0 to `ENTRIES-1`, which is what makes the permutation check on the ages meaningful.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;

  typedef enum logic {
    ST_LOOK = 1'b0,
    ST_WALK = 1'b1
  } walk_state_e;

  typedef enum logic [1:0] {
    LK_MISS = 2'd0,
    LK_HIT  = 2'd1,
    LK_PROT = 2'd2
  } look_kind_e;

  // Outcome of a lookup: the read-only check wins over the modified check
  function automatic look_kind_e classify(input logic match, input logic wr,
                                          input logic ro, input logic dirty);
    if (!match)        return LK_MISS;
    if (wr && ro)      return LK_PROT;
    if (wr && !dirty)  return LK_MISS;
    return LK_HIT;
  endfunction

endpackage

// File: rtl/fa_tlb_store.sv
module fa_tlb_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  logic               wr_ro,
  input  logic               wr_dirty,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic               hit_ro,
  output logic               hit_dirty
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [PFN_W-1:0]   frame_q [ENTRIES];
  logic [ENTRIES-1:0] ro_q;
  logic [ENTRIES-1:0] dirty_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel          = wr_en && (wr_idx == IDX_W'(g));
    assign match_vec[g] = valid_q[g] && (tag_q[g] == look_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n)      valid_q[g] <= 1'b0;
      else if (flush)  valid_q[g] <= 1'b0;
      else if (sel)    valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g]   <= wr_vpn;
        frame_q[g] <= wr_pfn;
        ro_q[g]    <= wr_ro;
        dirty_q[g] <= wr_dirty;
      end
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign valid_vec = valid_q;
  assign hit       = |match_vec;
  assign hit_pfn   = frame_q[hit_idx];
  assign hit_ro    = ro_q[hit_idx];
  assign hit_dirty = dirty_q[hit_idx];

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R4
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_vpn))));

endmodule

// File: rtl/fa_tlb_age.sv
module fa_tlb_age #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               use_en,
  input  logic [IDX_W-1:0]   use_idx,
  output logic [IDX_W-1:0]   victim_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] used_age;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;
  logic             any_free;

  assign used_age = age_q[use_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_q[g] <= IDX_W'(g);
      end else if (use_en) begin
        if (use_idx == IDX_W'(g))       age_q[g] <= '0;
        else if (age_q[g] < used_age)   age_q[g] <= age_q[g] + IDX_W'(1);
      end
    end
  end

  always_comb begin
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (age_q[i] == OLDEST) old_idx = IDX_W'(i);
    end
  end

  assign any_free   = !(&valid_vec);
  assign victim_idx = any_free ? free_idx : old_idx;

  // R9: ages stay a permutation, so exactly one slot holds each age
  for (genvar k = 0; k < ENTRIES; k++) begin : g_perm
    logic [ENTRIES-1:0] holds_k;
    for (genvar i = 0; i < ENTRIES; i++) begin : g_bit
      assign holds_k[i] = (age_q[i] == IDX_W'(k));
    end
    // R9
    age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(holds_k));
  end

  // R8
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> !valid_vec[victim_idx]);

endmodule

// File: rtl/fa_tlb_fsm.sv
module fa_tlb_fsm
  import fa_tlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic look_miss,
  input  logic walk_resp_valid,
  output logic walk_active
);

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_LOOK: if (req_valid && look_miss) state_d = ST_WALK;
      ST_WALK: if (walk_resp_valid)        state_d = ST_LOOK;
      default: state_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_LOOK;
    else        state_q <= state_d;
  end

  assign walk_active = (state_q == ST_WALK);

  // R3
  walk_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_active && !walk_resp_valid) |=> walk_active);

  // R3: the requester keeps its request up through the walk
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_active |-> req_valid);

endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
  import fa_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [VPN_W-1:0]         req_vpn,
  input  logic [OFF_W-1:0]         req_off,
  output logic                     resp_valid,
  output logic [PFN_W+OFF_W-1:0]   resp_paddr,
  output logic                     resp_prot_fault,
  output logic                     resp_walk_fault,
  output logic                     walk_req_valid,
  output logic [VPN_W-1:0]         walk_req_vpn,
  input  logic                     walk_resp_valid,
  input  logic [PFN_W-1:0]         walk_resp_pfn,
  input  logic                     walk_resp_ro,
  input  logic                     walk_resp_dirty,
  input  logic                     walk_resp_fault
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PA_W  = PFN_W + OFF_W;

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] frame,
                                              input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  logic               tag_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit_ro;
  logic               hit_dirty;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   fill_idx;
  logic               fill_en;
  logic               use_en;
  logic [IDX_W-1:0]   use_idx;
  logic               in_walk;
  logic               look_miss;
  look_kind_e         kind;

  assign kind      = classify(tag_hit, req_write, hit_ro, hit_dirty);
  assign look_miss = (kind == LK_MISS);
  // A modified-flag refill reuses the matching slot, so a tag never appears twice
  assign fill_idx  = tag_hit ? hit_idx : victim_idx;

  fa_tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .look_vpn (req_vpn),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_vpn   (req_vpn),
    .wr_pfn   (walk_resp_pfn),
    .wr_ro    (walk_resp_ro),
    .wr_dirty (walk_resp_dirty),
    .valid_vec(valid_vec),
    .match_vec(match_vec),
    .hit      (tag_hit),
    .hit_idx  (hit_idx),
    .hit_pfn  (hit_pfn),
    .hit_ro   (hit_ro),
    .hit_dirty(hit_dirty)
  );

  fa_tlb_age #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) age_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .use_en    (use_en),
    .use_idx   (use_idx),
    .victim_idx(victim_idx)
  );

  fa_tlb_fsm fsm_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .look_miss      (look_miss),
    .walk_resp_valid(walk_resp_valid),
    .walk_active    (in_walk)
  );

  always_comb begin
    resp_valid      = 1'b0;
    resp_paddr      = '0;
    resp_prot_fault = 1'b0;
    resp_walk_fault = 1'b0;
    fill_en         = 1'b0;
    use_en          = 1'b0;
    use_idx         = hit_idx;
    if (!in_walk) begin
      if (req_valid && !look_miss) begin
        resp_valid      = 1'b1;
        resp_paddr      = join_pa(hit_pfn, req_off);
        resp_prot_fault = (kind == LK_PROT);
        use_en          = 1'b1;
      end
    end else if (walk_resp_valid) begin
      resp_valid = 1'b1;
      if (walk_resp_fault) begin
        resp_walk_fault = 1'b1;
      end else begin
        resp_paddr      = join_pa(walk_resp_pfn, req_off);
        resp_prot_fault = req_write && walk_resp_ro;
        fill_en         = !flush;
        use_en          = !flush;
        use_idx         = fill_idx;
      end
    end
  end

  assign walk_req_valid = in_walk;
  assign walk_req_vpn   = req_vpn;

  // R6
  prot_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_prot_fault |-> (req_write && resp_valid));

  // R5
  walk_fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_walk_fault |-> ((resp_paddr == '0) && !resp_prot_fault && walk_req_valid));

  // R2
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !walk_req_valid) |-> ($onehot(match_vec) && req_valid));

  // R3
  walk_vpn_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_resp_valid) |=> (walk_req_valid && $stable(walk_req_vpn)));

  // R1
  walker_only_when_asked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_resp_valid |-> walk_req_valid);

endmodule

// File: tb/fa_tlb_tb_top.sv
`timescale 1ns/1ps
module fa_tlb_tb_top;

  localparam int CAP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_vpn = '0;
  logic [11:0] req_off = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        resp_prot_fault;
  logic        resp_walk_fault;
  logic        walk_req_valid;
  logic [19:0] walk_req_vpn;
  logic        walk_resp_valid = 1'b0;
  logic [19:0] walk_resp_pfn = '0;
  logic        walk_resp_ro = 1'b0;
  logic        walk_resp_dirty = 1'b0;
  logic        walk_resp_fault = 1'b0;

  always #2 clk = ~clk;

  fa_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_write(req_write), .req_vpn(req_vpn), .req_off(req_off),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_prot_fault(resp_prot_fault), .resp_walk_fault(resp_walk_fault),
    .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
    .walk_resp_valid(walk_resp_valid), .walk_resp_pfn(walk_resp_pfn),
    .walk_resp_ro(walk_resp_ro), .walk_resp_dirty(walk_resp_dirty),
    .walk_resp_fault(walk_resp_fault)
  );

  typedef struct {
    logic [19:0] vpn;
    logic [19:0] pfn;
    logic        ro;
    logic        dirty;
  } map_t;

  map_t model_q[$];   // most recently used at the front
  int nchk = 0;
  int nerr = 0;
  int lfsr = 32'h1ACE5;

  // Page table seen by the walker
  function automatic logic [19:0] pt_pfn(input logic [19:0] v);
    return v * 20'd13 + 20'd5;
  endfunction
  function automatic logic pt_fault(input logic [19:0] v);
    return v[4:0] == 5'h1F;
  endfunction

  function automatic int mfind(input logic [19:0] v);
    foreach (model_q[i]) if (model_q[i].vpn == v) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic next_rand(output int r);
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    r = lfsr & 32'h7FFF_FFFF;
  endtask

  task automatic do_req(input bit wr, input logic [19:0] vpn, input logic [11:0] off,
                        input int lat, input bit flush_at_resp, input string tag);
    int   idx;
    bit   miss;
    map_t e;
    idx  = mfind(vpn);
    miss = (idx < 0) || (wr && !model_q[idx].ro && !model_q[idx].dirty);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vpn = vpn; req_off = off;
    walk_resp_valid = 1'b0; flush = 1'b0;
    #1;
    if (!miss) begin
      chk(tag, "hit resp_valid", 64'(resp_valid), 64'(1));
      chk(tag, "hit paddr", 64'(resp_paddr), 64'({model_q[idx].pfn, off}));
      chk(tag, "hit prot", 64'(resp_prot_fault), 64'(wr && model_q[idx].ro));
      chk(tag, "hit no walk", 64'(walk_req_valid), 64'(0));
      e = model_q[idx];
      model_q.delete(idx);
      model_q.push_front(e);
    end else begin
      chk(tag, "R3 miss no resp", 64'(resp_valid), 64'(0));
      chk(tag, "R3 miss no walk yet", 64'(walk_req_valid), 64'(0));
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        #1;
        chk(tag, "R3 walk pending", 64'(walk_req_valid), 64'(1));
        chk(tag, "R3 walk vpn", 64'(walk_req_vpn), 64'(vpn));
        chk(tag, "R3 wait no resp", 64'(resp_valid), 64'(0));
      end
      @(negedge clk);
      walk_resp_valid = 1'b1;
      walk_resp_pfn   = pt_pfn(vpn);
      walk_resp_ro    = vpn[2];
      walk_resp_dirty = wr | vpn[3];
      walk_resp_fault = pt_fault(vpn);
      flush           = flush_at_resp;
      #1;
      chk(tag, "R3 walk vpn at resp", 64'(walk_req_vpn), 64'(vpn));
      chk(tag, "R4 fill resp_valid", 64'(resp_valid), 64'(1));
      if (pt_fault(vpn)) begin
        chk(tag, "R5 walk fault", 64'(resp_walk_fault), 64'(1));
        chk(tag, "R5 paddr zero", 64'(resp_paddr), 64'(0));
        chk(tag, "R5 no prot", 64'(resp_prot_fault), 64'(0));
      end else begin
        chk(tag, "R4 fill paddr", 64'(resp_paddr), 64'({pt_pfn(vpn), off}));
        chk(tag, "R6 fill prot", 64'(resp_prot_fault), 64'(wr && vpn[2]));
        chk(tag, "R5 no walk fault", 64'(resp_walk_fault), 64'(0));
      end
      if (flush_at_resp) begin
        model_q.delete();
      end else if (!pt_fault(vpn)) begin
        e.vpn = vpn; e.pfn = pt_pfn(vpn); e.ro = vpn[2]; e.dirty = wr | vpn[3];
        idx = mfind(vpn);
        if (idx >= 0) model_q.delete(idx);
        else if (model_q.size() == CAP) void'(model_q.pop_back());
        model_q.push_front(e);
      end
    end
  endtask

  task automatic do_idle();
    @(negedge clk);
    req_valid = 1'b0; walk_resp_valid = 1'b0; walk_resp_fault = 1'b0; flush = 1'b0;
    #1;
    chk("R1", "idle resp_valid", 64'(resp_valid), 64'(0));
    chk("R1", "idle walk", 64'(walk_req_valid), 64'(0));
  endtask

  task automatic do_flush();
    @(negedge clk);
    req_valid = 1'b0; walk_resp_valid = 1'b0; flush = 1'b1;
    #1;
    chk("R10", "flush cycle no resp", 64'(resp_valid), 64'(0));
    model_q.delete();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int r;
    int r2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "reset resp_valid", 64'(resp_valid), 64'(0));
    chk("R1", "reset walk", 64'(walk_req_valid), 64'(0));

    // R1 / R3 / R4: first access walks, second hits (R2)
    do_req(1'b0, 20'h00010, 12'h123, 2, 1'b0, "R1");
    do_req(1'b0, 20'h00010, 12'h456, 0, 1'b0, "R2");
    do_idle();

    // R10: flush drops the mapping
    do_flush();
    do_req(1'b0, 20'h00010, 12'h001, 0, 1'b0, "R10");

    // R8: eight distinct pages after a flush all stay cached
    do_flush();
    for (int i = 0; i < 8; i++) do_req(1'b0, 20'h00100 + 20'(i), 12'(i * 5), i % 3, 1'b0, "R8");
    for (int i = 0; i < 8; i++) do_req(1'b0, 20'h00100 + 20'(i), 12'hABC, 0, 1'b0, "R8");

    // R9: leave 0x103 least recent, then force replacements
    for (int i = 0; i < 8; i++) if (i != 3) do_req(1'b0, 20'h00100 + 20'(i), 12'h010, 0, 1'b0, "R9");
    do_req(1'b0, 20'h00200, 12'h020, 1, 1'b0, "R9");
    do_req(1'b0, 20'h00103, 12'h030, 0, 1'b0, "R9");
    do_req(1'b0, 20'h00101, 12'h040, 0, 1'b0, "R9");
    do_req(1'b0, 20'h00100, 12'h050, 0, 1'b0, "R9");
    do_idle();

    // R5: walker fault is reported and not cached
    do_req(1'b0, 20'h0001F, 12'h777, 1, 1'b0, "R5");
    do_req(1'b1, 20'h0001F, 12'h778, 0, 1'b0, "R5");

    // R6: read-only pages
    do_req(1'b0, 20'h00004, 12'h111, 0, 1'b0, "R6");
    do_req(1'b0, 20'h00004, 12'h112, 0, 1'b0, "R6");
    do_req(1'b1, 20'h00004, 12'h113, 0, 1'b0, "R6");
    do_req(1'b1, 20'h00014, 12'h114, 2, 1'b0, "R6");
    do_req(1'b1, 20'h00014, 12'h115, 0, 1'b0, "R6");

    // R7: write to a clean cached page refills in place
    do_req(1'b0, 20'h00040, 12'h222, 0, 1'b0, "R7");
    do_req(1'b1, 20'h00040, 12'h223, 1, 1'b0, "R7");
    do_req(1'b1, 20'h00040, 12'h224, 0, 1'b0, "R7");
    do_req(1'b0, 20'h00004, 12'h225, 0, 1'b0, "R7");
    do_req(1'b0, 20'h00014, 12'h226, 0, 1'b0, "R7");
    do_idle();

    // R11: flush together with the walker answer
    do_req(1'b0, 20'h00300, 12'h333, 1, 1'b1, "R11");
    do_req(1'b0, 20'h00300, 12'h334, 0, 1'b0, "R11");
    do_req(1'b0, 20'h00300, 12'h335, 0, 1'b0, "R11");

    // R9: mixed traffic over a pool larger than the cache
    for (int n = 0; n < 300; n++) begin
      next_rand(r);
      next_rand(r2);
      if (n % 75 == 74) do_flush();
      do_req(r2[0], 20'h00400 + 20'(r % 12), 12'(r2 >> 4), (r2 >> 2) % 3, 1'b0, "R9");
      if (r2[1]) do_idle();
    end
    do_idle();
    finish_run();
  end

endmodule